// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block sits between a bank of external interrupt lines and the interrupt messaging fabric. Every line owns a redirection entry that states how a request on that line is turned into a message: the vector, delivery mode, destination mode and destination to send. The entry also says whether the line is active low, whether it is level or edge sensitive, and whether it is masked. Hidden in each entry is a remote-pending flag that the block manages itself. The block keeps one request bit per line. A scanner visits the pending, unmasked lines from the lowest index upwards. It hands out one delivery message at a time on a valid/ready port.

Level-sensitive lines get a handshake with the interrupt consumer. Once such a line's message has gone out, the line stays silent until an end-of-interrupt broadcast arrives carrying that line's vector. If the line is still requesting at that point, it is served again. A line whose delivery mode selects an external interrupt controller takes its vector from that controller over a request/acknowledge port. Physical input 0 is folded onto entry 2, a fixed wiring convention, so entry 0 never requests anything. Entries are written through a simple indexed write port.

Top module: `irq_route_engine`

## Requirements
- R1: After reset every entry is masked with all other fields zero, all request bits are clear, `dlv_valid` and `ext_req` are low. Inputs held active through reset produce no message.
- R2: With remapping enabled, input 0 is ORed with input 2 and feeds entry 2. Entry 0 never receives a request. All other inputs drive the entry with the same index.
- R3: When `active_low` is set, the input is inverted. For an edge entry the active transition is then the falling one. Changing the polarity bit alone never creates a request.
- R4: For a level entry (`cfg_level`=1), the request bit follows the effective input level one clock later, whether or not the entry is masked. A masked level request is delivered once the entry is unmasked.
- R5: For an edge entry, an active transition sets the request bit only if the entry is unmasked. A masked transition is discarded and is not delivered after a later unmask. Holding or releasing the input does not clear a pending request or produce a second one.
- R6: A message carries the entry's destination, destination mode, delivery mode, vector and trigger mode (`dlv_level`=1 for level). Accepting the message of an edge line clears that line's request bit.
- R7: Accepting the message of a level line sets its remote-pending flag. The line produces no further message while the flag is set, even with its input still active.
- R8: An end-of-interrupt (`eoi_valid` with `eoi_vector`) clears the remote-pending flag of every entry whose vector matches. Any such line that is still requesting and unmasked is delivered again. A non-matching vector has no effect.
- R9: When the delivery mode is external (`3'b111`), `ext_req` rises and stays high until `ext_ack`. The message vector is the `ext_vector` value sampled with the acknowledge. No message is offered while the request is open.
- R10: Among pending lines the lowest index is delivered first. Each accepted message is followed by at least one cycle without `dlv_valid`.
- R11: While `dlv_valid` is high and `dlv_ready` low, `dlv_valid` stays high and all message fields stay unchanged.
- R12: A configuration write replaces every field of the entry except the remote-pending flag, which keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Raw interrupt lines |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_vector | input | 8 | Vector field |
| cfg_dlv_mode | input | 3 | Delivery mode field (3'b111 = external) |
| cfg_dst_mode | input | 1 | Destination mode field |
| cfg_dest | input | 8 | Destination field |
| cfg_active_low | input | 1 | Polarity field, 1 = active low |
| cfg_level | input | 1 | Trigger field, 1 = level |
| cfg_mask | input | 1 | Mask field, 1 = masked |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the broadcast |
| dlv_valid | output | 1 | Delivery message offered |
| dlv_ready | input | 1 | Consumer accepts the message |
| dlv_dest | output | 8 | Message destination |
| dlv_dst_mode | output | 1 | Message destination mode |
| dlv_mode | output | 3 | Message delivery mode |
| dlv_vector | output | 8 | Message vector |
| dlv_level | output | 1 | Message trigger mode, 1 = level |
| ext_req | output | 1 | Vector request to the external controller |
| ext_ack | input | 1 | External vector returned |
| ext_vector | input | 8 | Vector from the external controller |

## Verification
The hardest state to reach from the ports is a level line whose remote-pending flag is set while its input is still active. Only a matching broadcast may release that line, and neither a rewrite of its entry nor a foreign vector may do so. The bench gets there by raising the line and letting the message be accepted. While the input stays high it then issues a rewrite of the same entry, a broadcast with a neighbouring vector and finally the matching one, and counts messages after each step. Backpressure ordering is reached by holding `dlv_ready` low while three edge lines fire in the same cycle.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
// Shared field widths, codes and record types of the interrupt redirection engine.
package irq_route_pkg;
    parameter int VEC_W  = 8;
    parameter int DEST_W = 8;
    parameter int DM_W   = 3;
    // Delivery mode that takes the vector from the external controller.
    parameter logic [DM_W-1:0] DM_EXTINT = 3'b111;

    // One redirection entry as seen by the logic (remote-pending kept apart).
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [VEC_W-1:0]  vector;
        logic [DM_W-1:0]   dmode;
        logic              dst_mode;
        logic              active_low;
        logic              level;
        logic              mask;
    } redir_t;

    // One outgoing delivery message.
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              dst_mode;
        logic [DM_W-1:0]   dmode;
        logic [VEC_W-1:0]  vector;
        logic              level;
    } dlv_msg_t;
endpackage

// File: rtl/irq_line_cell.sv
`timescale 1ns/1ps
// Per-line request tracking.
// Applies polarity, detects the active transition on the raw input, and
// holds the request bit. Assumes the raw input is already synchronous to clk.
module irq_line_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic active_low,
    input  logic level_mode,
    input  logic masked,
    input  logic clr_req,
    output logic req_q
);
    logic raw_q;
    logic edge_hit;

    // Active transition: rising when active high, falling when active low.
    always_comb edge_hit = active_low ? (raw_q & ~raw_in) : (~raw_q & raw_in);

    // Request bit: level follows input; edge sets when unmasked, clears on delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            req_q <= 1'b0;
        end else begin
            raw_q <= raw_in;
            if (level_mode) begin
                req_q <= raw_in ^ active_low;
            end else if (edge_hit && !masked) begin
                req_q <= 1'b1;
            end else if (clr_req) begin
                req_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_entry_table.sv
`timescale 1ns/1ps
// Redirection entries and remote-pending flags.
// Writes replace an entry's fields; the remote-pending flag is set on accepted
// level deliveries and cleared by a matching end-of-interrupt broadcast.
// Assumes cfg_idx values at or above NUM_LINES are simply ignored.
module irq_entry_table
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int IDX_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  redir_t               cfg_entry,
    input  logic                 set_remote,
    input  logic [IDX_W-1:0]     set_idx,
    input  logic                 eoi_valid,
    input  logic [VEC_W-1:0]     eoi_vector,
    output redir_t               entry_o [NUM_LINES],
    output logic [NUM_LINES-1:0] remote_o
);
    localparam redir_t ENTRY_RST = '{mask: 1'b1, default: '0};

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ent
        logic hit_w;
        logic hit_set;
        logic hit_eoi;

        // Decode this line's write, delivery and broadcast events.
        always_comb begin
            hit_w   = cfg_we && (cfg_idx == IDX_W'(i));
            hit_set = set_remote && (set_idx == IDX_W'(i));
            hit_eoi = eoi_valid && remote_o[i] && (entry_o[i].vector == eoi_vector);
        end

        // Entry storage: reset to masked, replaced on write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_o[i] <= ENTRY_RST;
            end else if (hit_w) begin
                entry_o[i] <= cfg_entry;
            end
        end

        // Remote-pending flag: a new delivery wins over a same-cycle broadcast.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                remote_o[i] <= 1'b0;
            end else if (hit_set) begin
                remote_o[i] <= 1'b1;
            end else if (hit_eoi) begin
                remote_o[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_service_scan.sv
`timescale 1ns/1ps
// Service scanner.
// Picks the lowest eligible line, latches its message, optionally fetches the
// vector from the external controller, then offers the message until accepted.
// Assumes request and remote-pending updates from a commit are visible one
// cycle later, which is when the scanner next picks.
module irq_service_scan
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int IDX_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  redir_t               entry_i [NUM_LINES],
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [NUM_LINES-1:0] remote_i,
    input  logic                 dlv_ready,
    input  logic                 ext_ack,
    input  logic [VEC_W-1:0]     ext_vector,
    output dlv_msg_t             msg_o,
    output logic                 dlv_valid,
    output logic                 ext_req,
    output logic                 commit_o,
    output logic [IDX_W-1:0]     commit_idx_o,
    output logic                 commit_level_o
);
    typedef enum logic [1:0] {SC_PICK, SC_EXT, SC_SEND} scan_st_t;

    scan_st_t             state_q;
    logic [NUM_LINES-1:0] elig;
    logic                 found;
    logic [IDX_W-1:0]     pick;
    logic [IDX_W-1:0]     idx_q;
    dlv_msg_t             msg_q;

    // Eligible lines: requesting, unmasked, and not awaiting end-of-interrupt.
    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            elig[i] = req_i[i] && !entry_i[i].mask && !(entry_i[i].level && remote_i[i]);
        end
    end

    // Lowest-index priority pick.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end

    // Scan state machine with message latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_PICK;
            idx_q   <= '0;
            msg_q   <= '0;
        end else begin
            case (state_q)
                SC_PICK: begin
                    if (found) begin
                        idx_q          <= pick;
                        msg_q.dest     <= entry_i[pick].dest;
                        msg_q.dst_mode <= entry_i[pick].dst_mode;
                        msg_q.dmode    <= entry_i[pick].dmode;
                        msg_q.vector   <= entry_i[pick].vector;
                        msg_q.level    <= entry_i[pick].level;
                        state_q <= (entry_i[pick].dmode == DM_EXTINT) ? SC_EXT : SC_SEND;
                    end
                end
                SC_EXT: begin
                    if (ext_ack) begin
                        msg_q.vector <= ext_vector;
                        state_q      <= SC_SEND;
                    end
                end
                SC_SEND: begin
                    if (dlv_ready) begin
                        state_q <= SC_PICK;
                    end
                end
                default: state_q <= SC_PICK;
            endcase
        end
    end

    // Port-facing outputs and the commit pulse to the line state.
    always_comb begin
        msg_o          = msg_q;
        dlv_valid      = (state_q == SC_SEND);
        ext_req        = (state_q == SC_EXT);
        commit_o       = (state_q == SC_SEND) && dlv_ready;
        commit_idx_o   = idx_q;
        commit_level_o = msg_q.level;
    end
endmodule

// File: rtl/irq_route_engine.sv
`timescale 1ns/1ps
// Interrupt redirection and delivery engine (top).
// Maps raw lines onto entries (input 0 folded onto entry 2 when REMAP_EN),
// tracks requests per line, and delivers one message at a time.
// Assumes irq_in is synchronous to clk; NUM_LINES >= 3 when REMAP_EN is set.
module irq_route_engine
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter bit REMAP_EN  = 1'b1,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [VEC_W-1:0]     cfg_vector,
    input  logic [DM_W-1:0]      cfg_dlv_mode,
    input  logic                 cfg_dst_mode,
    input  logic [DEST_W-1:0]    cfg_dest,
    input  logic                 cfg_active_low,
    input  logic                 cfg_level,
    input  logic                 cfg_mask,
    input  logic                 eoi_valid,
    input  logic [VEC_W-1:0]     eoi_vector,
    output logic                 dlv_valid,
    input  logic                 dlv_ready,
    output logic [DEST_W-1:0]    dlv_dest,
    output logic                 dlv_dst_mode,
    output logic [DM_W-1:0]      dlv_mode,
    output logic [VEC_W-1:0]     dlv_vector,
    output logic                 dlv_level,
    output logic                 ext_req,
    input  logic                 ext_ack,
    input  logic [VEC_W-1:0]     ext_vector
);
    redir_t               cfg_entry;
    redir_t               entry [NUM_LINES];
    logic [NUM_LINES-1:0] line_raw;
    logic [NUM_LINES-1:0] line_req;
    logic [NUM_LINES-1:0] line_remote;
    dlv_msg_t             msg;
    logic                 commit;
    logic [IDX_W-1:0]     commit_idx;
    logic                 commit_level;

    // Assemble the written entry from the configuration fields.
    always_comb begin
        cfg_entry.dest       = cfg_dest;
        cfg_entry.vector     = cfg_vector;
        cfg_entry.dmode      = cfg_dlv_mode;
        cfg_entry.dst_mode   = cfg_dst_mode;
        cfg_entry.active_low = cfg_active_low;
        cfg_entry.level      = cfg_level;
        cfg_entry.mask       = cfg_mask;
    end

    // Input-to-entry mapping, with the optional fold of input 0 onto entry 2.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_map
        if (REMAP_EN && i == 0) begin : g_zero
            always_comb line_raw[i] = 1'b0;
        end else if (REMAP_EN && i == 2) begin : g_two
            always_comb line_raw[i] = irq_in[2] | irq_in[0];
        end else begin : g_same
            always_comb line_raw[i] = irq_in[i];
        end
    end

    // One request cell per line.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic clr_i;
        always_comb clr_i = commit && !commit_level && (commit_idx == IDX_W'(i));
        irq_line_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_in     (line_raw[i]),
            .active_low (entry[i].active_low),
            .level_mode (entry[i].level),
            .masked     (entry[i].mask),
            .clr_req    (clr_i),
            .req_q      (line_req[i])
        );
    end

    irq_entry_table #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_entry  (cfg_entry),
        .set_remote (commit && commit_level),
        .set_idx    (commit_idx),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .entry_o    (entry),
        .remote_o   (line_remote)
    );

    irq_service_scan #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_scan (
        .clk            (clk),
        .rst_n          (rst_n),
        .entry_i        (entry),
        .req_i          (line_req),
        .remote_i       (line_remote),
        .dlv_ready      (dlv_ready),
        .ext_ack        (ext_ack),
        .ext_vector     (ext_vector),
        .msg_o          (msg),
        .dlv_valid      (dlv_valid),
        .ext_req        (ext_req),
        .commit_o       (commit),
        .commit_idx_o   (commit_idx),
        .commit_level_o (commit_level)
    );

    // Break the message record out onto the ports.
    always_comb begin
        dlv_dest     = msg.dest;
        dlv_dst_mode = msg.dst_mode;
        dlv_mode     = msg.dmode;
        dlv_vector   = msg.vector;
        dlv_level    = msg.level;
    end
endmodule

// File: rtl/irq_route_engine_chk.sv
`timescale 1ns/1ps
// Protocol checker for irq_route_engine, attached by bind below.
// Watches the delivery and external-vector handshakes only through ports.
module irq_route_engine_chk
    import irq_route_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dlv_valid,
    input logic              dlv_ready,
    input logic [DEST_W-1:0] dlv_dest,
    input logic              dlv_dst_mode,
    input logic [DM_W-1:0]   dlv_mode,
    input logic [VEC_W-1:0]  dlv_vector,
    input logic              dlv_level,
    input logic              ext_req,
    input logic              ext_ack
);
    // R1: first cycle out of reset is quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!dlv_valid && !ext_req));

    // R11: an offered message is held unchanged until accepted.
    assert_msg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_vector) && $stable(dlv_dest)
            && $stable(dlv_mode) && $stable(dlv_dst_mode) && $stable(dlv_level)));

    // R9: the external request stays open until acknowledged.
    assert_ext_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ack) |=> ext_req);

    // R9: no message is offered while an external vector is outstanding.
    assert_ext_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> !dlv_valid);

    // R9: an external-mode message only appears right after an acknowledge.
    assert_ext_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dlv_valid) && dlv_mode == DM_EXTINT) |-> $past(ext_ack));

    // R10: an accepted message is followed by a cycle with nothing offered.
    assert_one_per_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_ready) |=> !dlv_valid);
endmodule

bind irq_route_engine irq_route_engine_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dlv_valid    (dlv_valid),
    .dlv_ready    (dlv_ready),
    .dlv_dest     (dlv_dest),
    .dlv_dst_mode (dlv_dst_mode),
    .dlv_mode     (dlv_mode),
    .dlv_vector   (dlv_vector),
    .dlv_level    (dlv_level),
    .ext_req      (ext_req),
    .ext_ack      (ext_ack)
);

// File: tb/irq_route_engine_tb.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every line, then walks the corner cases.
module irq_route_engine_tb;
    localparam int NL    = 24;
    localparam int IDX_W = $clog2(NL);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   irq_in = '0;
    logic            cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [7:0]      cfg_vector = '0;
    logic [2:0]      cfg_dlv_mode = '0;
    logic            cfg_dst_mode = 1'b0;
    logic [7:0]      cfg_dest = '0;
    logic            cfg_active_low = 1'b0;
    logic            cfg_level = 1'b0;
    logic            cfg_mask = 1'b1;
    logic            eoi_valid = 1'b0;
    logic [7:0]      eoi_vector = '0;
    logic            dlv_valid;
    logic            dlv_ready = 1'b1;
    logic [7:0]      dlv_dest;
    logic            dlv_dst_mode;
    logic [2:0]      dlv_mode;
    logic [7:0]      dlv_vector;
    logic            dlv_level;
    logic            ext_req;
    logic            ext_ack = 1'b0;
    logic [7:0]      ext_vector = '0;

    int n_chk = 0;
    int n_err = 0;
    int n_msg = 0;
    bit done  = 1'b0;
    logic [7:0] m_vec  [0:255];
    logic [7:0] m_dest [0:255];
    logic [2:0] m_mode [0:255];
    logic       m_dstm [0:255];
    logic       m_lvl  [0:255];

    always #4 clk = ~clk;

    irq_route_engine #(.NUM_LINES(NL), .REMAP_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vector(cfg_vector),
        .cfg_dlv_mode(cfg_dlv_mode), .cfg_dst_mode(cfg_dst_mode), .cfg_dest(cfg_dest),
        .cfg_active_low(cfg_active_low), .cfg_level(cfg_level), .cfg_mask(cfg_mask),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_dest(dlv_dest),
        .dlv_dst_mode(dlv_dst_mode), .dlv_mode(dlv_mode), .dlv_vector(dlv_vector),
        .dlv_level(dlv_level), .ext_req(ext_req), .ext_ack(ext_ack), .ext_vector(ext_vector)
    );

    // Log every accepted message (sampled half a cycle before the accepting edge).
    always @(negedge clk) begin
        if (rst_n && dlv_valid && dlv_ready) begin
            m_vec[n_msg % 256]  = dlv_vector;
            m_dest[n_msg % 256] = dlv_dest;
            m_mode[n_msg % 256] = dlv_mode;
            m_dstm[n_msg % 256] = dlv_dst_mode;
            m_lvl[n_msg % 256]  = dlv_level;
            n_msg++;
        end
    end

    // External controller model: acknowledge four cycles after a request.
    initial begin
        forever begin
            @(negedge clk);
            if (ext_req && !ext_ack) begin
                repeat (4) @(negedge clk);
                ext_vector = 8'hC5;
                ext_ack    = 1'b1;
                @(negedge clk);
                ext_ack    = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cfg(input int idx, input int vec, input int dm, input int dstm,
                       input int dest, input bit al, input bit lvl, input bit msk);
        cfg_idx = IDX_W'(idx); cfg_vector = 8'(vec); cfg_dlv_mode = 3'(dm);
        cfg_dst_mode = dstm[0]; cfg_dest = 8'(dest);
        cfg_active_low = al; cfg_level = lvl; cfg_mask = msk;
        cfg_we = 1'b1;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic eoi(input int v);
        eoi_vector = 8'(v);
        eoi_valid  = 1'b1;
        cyc(1);
        eoi_valid  = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    initial begin
        int base;
        int saved_vec;
        // R1: inputs active through reset, all entries masked afterwards.
        irq_in = '1;
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        chk("R1", "dlv_valid after reset", dlv_valid, 0);
        chk("R1", "ext_req after reset", ext_req, 0);
        cyc(10);
        chk("R1", "messages from masked reset entries", n_msg, 0);
        irq_in = '0;
        cyc(3);

        // R5/R6: sweep every line as an edge entry with distinct fields.
        for (int i = 1; i < NL; i++) begin
            base = n_msg;
            cfg(i, 8'h40 + i, i % 4, i & 1, (i * 7) & 255, 1'b0, 1'b0, 1'b0);
            irq_in[i] = 1'b1;
            cyc(1 + (i % 3));
            irq_in[i] = 1'b0;
            cyc(10);
            chk("R5", $sformatf("line %0d message count", i), n_msg - base, 1);
            chk("R6", $sformatf("line %0d vector", i), m_vec[base % 256], 8'h40 + i);
            chk("R6", $sformatf("line %0d dest", i), m_dest[base % 256], (i * 7) & 255);
            chk("R6", $sformatf("line %0d mode", i), m_mode[base % 256], i % 4);
            chk("R6", $sformatf("line %0d dst mode", i), m_dstm[base % 256], i & 1);
            chk("R6", $sformatf("line %0d trigger", i), m_lvl[base % 256], 0);
        end

        // R2: input 0 lands on entry 2, entry 0 stays silent.
        cfg(0, 8'h70, 0, 0, 1, 1'b0, 1'b0, 1'b0);
        base = n_msg;
        irq_in[0] = 1'b1; cyc(1); irq_in[0] = 1'b0;
        cyc(10);
        chk("R2", "input 0 message count", n_msg - base, 1);
        chk("R2", "input 0 vector is entry 2", m_vec[base % 256], 8'h42);

        // R3: polarity rewrite alone is silent; falling transition requests.
        base = n_msg;
        cfg(5, 8'h65, 1, 0, 9, 1'b1, 1'b0, 1'b0);
        cyc(10);
        chk("R3", "no request from polarity change", n_msg - base, 0);
        irq_in[5] = 1'b1; cyc(10);
        chk("R3", "inactive-going rise ignored", n_msg - base, 0);
        irq_in[5] = 1'b0; cyc(10);
        chk("R3", "falling edge delivered", n_msg - base, 1);
        chk("R3", "falling edge vector", m_vec[base % 256], 8'h65);

        // R5: a masked edge is dropped and not revived by unmasking.
        base = n_msg;
        cfg(6, 8'h66, 0, 0, 6, 1'b0, 1'b0, 1'b1);
        irq_in[6] = 1'b1; cyc(1); irq_in[6] = 1'b0;
        cyc(3);
        cfg(6, 8'h66, 0, 0, 6, 1'b0, 1'b0, 1'b0);
        cyc(10);
        chk("R5", "masked edge discarded", n_msg - base, 0);

        // R4/R7/R8/R12: level line with remote-pending handshake.
        base = n_msg;
        cfg(7, 8'h91, 2, 1, 7, 1'b0, 1'b1, 1'b0);
        irq_in[7] = 1'b1;
        cyc(10);
        chk("R4", "level delivered once", n_msg - base, 1);
        chk("R6", "level trigger bit", m_lvl[base % 256], 1);
        chk("R4", "level vector", m_vec[base % 256], 8'h91);
        cyc(20);
        chk("R7", "held level not repeated", n_msg - base, 1);
        cfg(7, 8'h91, 2, 1, 7, 1'b0, 1'b1, 1'b0);
        cyc(10);
        chk("R12", "rewrite keeps remote-pending", n_msg - base, 1);
        eoi(8'h92); cyc(10);
        chk("R8", "foreign vector ignored", n_msg - base, 1);
        eoi(8'h91); cyc(10);
        chk("R8", "matching vector re-delivers", n_msg - base, 2);
        irq_in[7] = 1'b0; cyc(3);
        eoi(8'h91); cyc(10);
        chk("R8", "released line not re-delivered", n_msg - base, 2);

        // R4: masked level request survives until unmask.
        base = n_msg;
        cfg(8, 8'hA0, 0, 0, 8, 1'b0, 1'b1, 1'b1);
        irq_in[8] = 1'b1; cyc(10);
        chk("R4", "masked level held back", n_msg - base, 0);
        cfg(8, 8'hA0, 0, 0, 8, 1'b0, 1'b1, 1'b0);
        cyc(10);
        chk("R4", "unmasked level delivered", n_msg - base, 1);
        irq_in[8] = 1'b0; cyc(2); eoi(8'hA0); cyc(3);

        // R9: external-vector mode.
        base = n_msg;
        cfg(9, 8'h33, 7, 0, 3, 1'b0, 1'b0, 1'b0);
        irq_in[9] = 1'b1; cyc(1); irq_in[9] = 1'b0;
        cyc(3);
        chk("R9", "ext_req open", ext_req, 1);
        chk("R9", "no message while fetching", dlv_valid, 0);
        cyc(12);
        chk("R9", "external message count", n_msg - base, 1);
        chk("R9", "vector from external port", m_vec[base % 256], 8'hC5);
        chk("R9", "external mode field", m_mode[base % 256], 7);

        // R10/R11: simultaneous lines under backpressure.
        base = n_msg;
        cfg(10, 8'h5A, 0, 0, 10, 1'b0, 1'b0, 1'b0);
        cfg(11, 8'h5B, 0, 0, 11, 1'b0, 1'b0, 1'b0);
        cfg(12, 8'h5C, 0, 0, 12, 1'b0, 1'b0, 1'b0);
        dlv_ready = 1'b0;
        irq_in[12:10] = 3'b111; cyc(1); irq_in[12:10] = 3'b000;
        cyc(6);
        chk("R10", "lowest line offered first", dlv_valid ? int'(dlv_vector) : -1, 8'h5A);
        saved_vec = dlv_vector;
        cyc(5);
        chk("R11", "valid held under backpressure", dlv_valid, 1);
        chk("R11", "vector stable under backpressure", dlv_vector, saved_vec);
        dlv_ready = 1'b1;
        cyc(15);
        chk("R10", "three messages", n_msg - base, 3);
        chk("R10", "order 1", m_vec[base % 256], 8'h5A);
        chk("R10", "order 2", m_vec[(base + 1) % 256], 8'h5B);
        chk("R10", "order 3", m_vec[(base + 2) % 256], 8'h5C);

        // R8: one broadcast releases every matching entry.
        base = n_msg;
        cfg(13, 8'hB0, 0, 0, 13, 1'b0, 1'b1, 1'b0);
        cfg(14, 8'hB0, 0, 0, 14, 1'b0, 1'b1, 1'b0);
        irq_in[14:13] = 2'b11; cyc(15);
        chk("R8", "two level lines delivered", n_msg - base, 2);
        eoi(8'hB0); cyc(15);
        chk("R8", "shared vector re-delivers both", n_msg - base, 4);
        irq_in[14:13] = 2'b00; cyc(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule